// File: doc/BRIEF.md
# Buck Converter Overcurrent and Hiccup Protection Sequencer

This block is the digital protection sequencer that sits beside the analog control loop of a valley-current-mode step-down converter. In each switching cycle it watches the low-side current comparator while the low-side switch conducts. When the current is still above the limit, it holds the low-side switch on. Once the current has fallen back below the limit, it ends the cycle with a strobe, so that the next cycle starts at once. After a current-limited cycle the loop is told to use a fixed on-time. A run of current-limited cycles makes it switch the analog comparator to a lower threshold, which folds the output current back. Any cycle that ends without reaching the limit clears all of this.

The block also owns shutdown. An undervoltage flag on the feedback path is debounced over a programmable number of clocks, and only while soft-start has finished. A confirmed undervoltage turns the converter off for a programmable hiccup interval, after which a restart pulse asks the soft-start logic to ramp again. Input undervoltage and over-temperature turn the converter off for as long as either is present. These shutdowns do not latch: a restart pulse follows as soon as both flags clear.

Top module: `buck_guard`

## Requirements
- R1: Reset drives every output (`ls_hold_o`, `cyc_term_o`, `fixed_ton_o`, `ilim_low_o`, `pwr_off_o`, `restart_o`) to 0.
- R2: When `ls_on_i` and `ilim_i` are both sampled high while running, `ls_hold_o` is 1 after that clock edge. It stays 1 until an edge samples `ilim_i` low. At that edge `ls_hold_o` returns to 0 and `cyc_term_o` is 1 for exactly one clock.
- R3: From the edge that ends a current-limited cycle with `cyc_term_o`, `fixed_ton_o` is 1. It stays 1 until a cycle closes cleanly.
- R4: At the edge that ends the FOLD_RUN-th consecutive current-limited cycle (default 7), `ilim_low_o` becomes 1. After only FOLD_RUN-1 such cycles it is still 0.
- R5: A clean cycle end clears the run count, `ilim_low_o` and `fixed_ton_o` at the next edge. A clean cycle end is `cyc_end_i` sampled high while no hold is active and no hold is starting. A later fold-back again needs the full run of FOLD_RUN cycles.
- R6: `cyc_end_i` has no effect while a hold is active. When it arrives in the same clock as a new overcurrent detection, the hold starts and the count is kept.
- R7: `pwr_off_o` rises after `uv_i` has been sampled high on UV_CYC consecutive edges while `ss_busy_i` is low. A single low sample restarts the count.
- R8: While `ss_busy_i` is 1, `uv_i` is ignored and the debounce count stays at zero.
- R9: An undervoltage shutdown keeps `pwr_off_o` high for exactly HICCUP_CYC clocks. Then `pwr_off_o` falls and `restart_o` is 1 for one clock.
- R10: `vin_low_i` or `hot_i` sampled high forces `pwr_off_o` high at the next edge, and it stays high while either flag is present. This holds during a hiccup as well, where the hiccup timer then has no effect. The first edge that samples both flags low clears `pwr_off_o` and pulses `restart_o`.
- R11: From the second clock of a shutdown, `ls_hold_o`, `cyc_term_o`, `fixed_ton_o` and `ilim_low_o` are 0, and `ls_on_i`, `ilim_i` and `cyc_end_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_on_i | input | 1 | Low-side conduction window from the on-time logic |
| ilim_i | input | 1 | Sensed switch current above the selected limit |
| cyc_end_i | input | 1 | Normal end-of-cycle strobe from the on-time logic |
| uv_i | input | 1 | Feedback below the undervoltage fraction of target |
| ss_busy_i | input | 1 | Soft-start ramp still in progress |
| vin_low_i | input | 1 | Input supply below its lockout level |
| hot_i | input | 1 | Die temperature above the shutdown level |
| ls_hold_o | output | 1 | Keep the low-side switch on |
| cyc_term_o | output | 1 | One-clock strobe ending a current-limited cycle |
| fixed_ton_o | output | 1 | Use the fixed on-time instead of the adaptive one |
| ilim_low_o | output | 1 | Select the lower current-limit threshold |
| pwr_off_o | output | 1 | Converter switching disabled |
| restart_o | output | 1 | One-clock request to rerun soft-start |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the normal end-of-cycle strobe and the start of an overcurrent hold. The bench drives `cyc_end_i` together with `ls_on_i` and `ilim_i`, and also during an active hold. A correct design shows `ls_hold_o` high, and `fixed_ton_o` and `ilim_low_o` keep the values they had. The second pair is a pending hiccup timer and a supply or thermal fault. The bench raises `vin_low_i` in the middle of a hiccup and keeps it high past the hiccup length. It then checks that `pwr_off_o` stays high and that `restart_o` comes only after the fault flag drops.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_HICCUP = 2'd1,
        PS_OFF    = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/bg_valley_limit.sv
module bg_valley_limit #(
    parameter int FOLD_RUN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ls_on_i,
    input  logic ilim_i,
    input  logic cyc_end_i,
    output logic hold_o,
    output logic term_o,
    output logic fixed_o,
    output logic low_o
);
    localparam int SW = $clog2(FOLD_RUN + 1);
    localparam logic [SW-1:0] RUN_MAX  = SW'(FOLD_RUN);
    localparam logic [SW-1:0] RUN_LAST = SW'(FOLD_RUN - 1);

    typedef struct packed {
        logic          hold;
        logic          term;
        logic          fixed;
        logic          low;
        logic [SW-1:0] streak;
    } vl_state_t;

    vl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        if (!run_i) begin
            st_d = '0;
        end else if (st_q.hold) begin
            if (!ilim_i) begin
                st_d.hold  = 1'b0;
                st_d.term  = 1'b1;
                st_d.fixed = 1'b1;
                if (st_q.streak != RUN_MAX) begin
                    st_d.streak = st_q.streak + 1'b1;
                end
                if (st_q.streak >= RUN_LAST) begin
                    st_d.low = 1'b1;
                end
            end
        end else if (ls_on_i && ilim_i) begin
            st_d.hold = 1'b1;
        end else if (cyc_end_i) begin
            st_d.streak = '0;
            st_d.low    = 1'b0;
            st_d.fixed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o  = st_q.hold;
    assign term_o  = st_q.term;
    assign fixed_o = st_q.fixed;
    assign low_o   = st_q.low;

endmodule

// File: rtl/bg_uv_debounce.sv
module bg_uv_debounce #(
    parameter int UV_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic uv_i,
    output logic trip_o
);
    localparam int CW = (UV_CYC > 1) ? $clog2(UV_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(UV_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } db_state_t;

    db_state_t st_d, st_q;
    logic      trip;

    always_comb begin
        st_d = st_q;
        trip = arm_i && uv_i && (st_q.cnt == CNT_LAST);
        if (!arm_i || !uv_i || trip) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o = trip;

endmodule

// File: rtl/bg_fault_seq.sv
module bg_fault_seq
    import buck_guard_pkg::*;
#(
    parameter int HICCUP_CYC = 1750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic trip_i,
    output logic run_o,
    output logic off_o,
    output logic restart_o
);
    localparam int HW = (HICCUP_CYC > 1) ? $clog2(HICCUP_CYC) : 1;
    localparam logic [HW-1:0] HIC_LAST = HW'(HICCUP_CYC - 1);

    typedef struct packed {
        pwr_state_e    state;
        logic [HW-1:0] hic_cnt;
        logic          restart;
    } fs_state_t;

    fs_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        unique case (st_q.state)
            PS_RUN: begin
                if (fault_i) begin
                    st_d.state = PS_OFF;
                end else if (trip_i) begin
                    st_d.state   = PS_HICCUP;
                    st_d.hic_cnt = '0;
                end
            end
            PS_HICCUP: begin
                if (fault_i) begin
                    st_d.state = PS_OFF;
                end else if (st_q.hic_cnt == HIC_LAST) begin
                    st_d.state   = PS_RUN;
                    st_d.restart = 1'b1;
                end else begin
                    st_d.hic_cnt = st_q.hic_cnt + 1'b1;
                end
            end
            PS_OFF: begin
                if (!fault_i) begin
                    st_d.state   = PS_RUN;
                    st_d.restart = 1'b1;
                end
            end
            default: st_d.state = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PS_RUN, hic_cnt: '0, restart: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o     = (st_q.state == PS_RUN);
    assign off_o     = (st_q.state != PS_RUN);
    assign restart_o = st_q.restart;

endmodule

// File: rtl/buck_guard.sv
module buck_guard #(
    parameter int FOLD_RUN   = 7,
    parameter int UV_CYC     = 1250,
    parameter int HICCUP_CYC = 1750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_on_i,
    input  logic ilim_i,
    input  logic cyc_end_i,
    input  logic uv_i,
    input  logic ss_busy_i,
    input  logic vin_low_i,
    input  logic hot_i,
    output logic ls_hold_o,
    output logic cyc_term_o,
    output logic fixed_ton_o,
    output logic ilim_low_o,
    output logic pwr_off_o,
    output logic restart_o
);
    logic run;
    logic uv_trip;
    logic fault;

    assign fault = vin_low_i || hot_i;

    bg_valley_limit #(.FOLD_RUN(FOLD_RUN)) u_valley (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .ls_on_i  (ls_on_i),
        .ilim_i   (ilim_i),
        .cyc_end_i(cyc_end_i),
        .hold_o   (ls_hold_o),
        .term_o   (cyc_term_o),
        .fixed_o  (fixed_ton_o),
        .low_o    (ilim_low_o)
    );

    bg_uv_debounce #(.UV_CYC(UV_CYC)) u_uvdb (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (run && !ss_busy_i),
        .uv_i  (uv_i),
        .trip_o(uv_trip)
    );

    bg_fault_seq #(.HICCUP_CYC(HICCUP_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (fault),
        .trip_i   (uv_trip),
        .run_o    (run),
        .off_o    (pwr_off_o),
        .restart_o(restart_o)
    );

endmodule

// File: rtl/buck_guard_chk.sv
module buck_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic vin_low_i,
    input logic hot_i,
    input logic ls_hold_o,
    input logic cyc_term_o,
    input logic fixed_ton_o,
    input logic ilim_low_o,
    input logic pwr_off_o,
    input logic restart_o
);
    AST_TERM_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_term_o |-> $past(ls_hold_o)); // R2
    AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_term_o |=> !cyc_term_o); // R2
    AST_HOLD_ENDS_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ls_hold_o) && !pwr_off_o) |-> cyc_term_o); // R2
    AST_LOW_IMPLIES_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_low_o |-> fixed_ton_o); // R4
    AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (vin_low_i || hot_i) |=> pwr_off_o); // R10
    AST_RESTART_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (!pwr_off_o && $past(pwr_off_o))); // R9
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off_o && $past(pwr_off_o)) |-> (!ls_hold_o && !cyc_term_o && !ilim_low_o)); // R11
endmodule

bind buck_guard buck_guard_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vin_low_i  (vin_low_i),
    .hot_i      (hot_i),
    .ls_hold_o  (ls_hold_o),
    .cyc_term_o (cyc_term_o),
    .fixed_ton_o(fixed_ton_o),
    .ilim_low_o (ilim_low_o),
    .pwr_off_o  (pwr_off_o),
    .restart_o  (restart_o)
);

// File: tb/buck_guard_tb_top.sv
module buck_guard_tb_top;
    localparam int FOLD = 7;
    localparam int UVC  = 6;
    localparam int HIC  = 10;
    localparam int NVEC = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ls_on = 0, ilim = 0, cyc_end = 0, uv = 0, ss_busy = 0, vin_low = 0, hot = 0;
    logic hold, term, fixed, low, off, restart;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    buck_guard #(.FOLD_RUN(FOLD), .UV_CYC(UVC), .HICCUP_CYC(HIC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ls_on_i(ls_on), .ilim_i(ilim), .cyc_end_i(cyc_end),
        .uv_i(uv), .ss_busy_i(ss_busy), .vin_low_i(vin_low), .hot_i(hot),
        .ls_hold_o(hold), .cyc_term_o(term), .fixed_ton_o(fixed), .ilim_low_o(low),
        .pwr_off_o(off), .restart_o(restart)
    );

    // {ls_on, ilim, cyc_end, exp_hold, exp_term, exp_fixed, exp_low}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b101_0000, // R5 clean end
        7'b110_1000, // R2 hold starts
        7'b111_1000, // R6 end strobe during hold ignored
        7'b100_0110, // R2 R3 term, 1 cycle
        7'b110_1010, 7'b100_0110, // 2
        7'b110_1010, 7'b100_0110, // 3
        7'b110_1010, 7'b100_0110, // 4
        7'b110_1010, 7'b100_0110, // 5
        7'b110_1010, 7'b100_0110, // 6: R4 still high limit
        7'b110_1010, 7'b100_0111, // 7: R4 fold-back
        7'b110_1011, 7'b100_0111, // 8: saturated
        7'b001_0000, // R5 clean end clears
        7'b111_1000, // R6 coincident: hold wins
        7'b100_0110, // R2 term
        7'b000_0010  // R3 fixed kept while idle
    };

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic oc_cycle();
        ls_on = 1; ilim = 1; cyc_end = 0; step();
        ilim = 0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1", "hold", hold, 0);  chk("R1", "term", term, 0);
        chk("R1", "fixed", fixed, 0); chk("R1", "low", low, 0);
        chk("R1", "off", off, 0);    chk("R1", "restart", restart, 0);
        rst_n = 1; step();

        for (int i = 0; i < NVEC; i++) begin
            {ls_on, ilim, cyc_end} = VEC[i][6:4];
            step();
            chk("R2", $sformatf("vec%0d hold", i), hold, VEC[i][3]);
            chk("R2", $sformatf("vec%0d term", i), term, VEC[i][2]);
            chk("R3", $sformatf("vec%0d fixed", i), fixed, VEC[i][1]);
            chk("R4", $sformatf("vec%0d low", i), low, VEC[i][0]);
        end
        ls_on = 0; ilim = 0; cyc_end = 1; step(); cyc_end = 0;
        chk("R5", "fixed cleared", fixed, 0);

        // R8: soft-start masks undervoltage
        ss_busy = 1; uv = 1;
        repeat (UVC + 3) step();
        chk("R8", "masked off", off, 0);
        ss_busy = 0;
        repeat (UVC - 1) step();
        chk("R8", "count restarted from zero", off, 0);
        // R7: a drop restarts the debounce
        uv = 0; step();
        uv = 1;
        repeat (UVC - 1) step();
        chk("R7", "short run no trip", off, 0);
        step();
        chk("R7", "trip", off, 1);
        uv = 0;
        // R9: hiccup length and restart pulse
        for (int k = 1; k < HIC; k++) begin
            step();
            chk("R9", $sformatf("hiccup %0d off", k), off, 1);
            chk("R9", $sformatf("hiccup %0d restart", k), restart, 0);
        end
        step();
        chk("R9", "hiccup end off", off, 0);
        chk("R9", "restart pulse", restart, 1);
        step();
        chk("R9", "restart single", restart, 0);

        // R10: thermal shutdown, non-latching
        hot = 1; step();
        chk("R10", "hot off", off, 1);
        repeat (3) step();
        chk("R10", "hot held", off, 1);
        hot = 0; step();
        chk("R10", "hot clear off", off, 0);
        chk("R10", "hot clear restart", restart, 1);

        // R10: fault during hiccup overrides timer
        uv = 1; repeat (UVC) step(); uv = 0;
        chk("R7", "second trip", off, 1);
        repeat (3) step();
        vin_low = 1;
        repeat (HIC + 2) step();
        chk("R10", "fault beats hiccup", off, 1);
        chk("R10", "no restart in fault", restart, 0);
        vin_low = 0; step();
        chk("R10", "vin clear restart", restart, 1);
        chk("R10", "vin clear on", off, 0);

        // R11: shutdown clears fold-back and ignores switching inputs
        repeat (FOLD) oc_cycle();
        chk("R4", "fold-back before fault", low, 1);
        ls_on = 1; ilim = 1; hot = 1;
        repeat (2) step();
        chk("R11", "hold off", hold, 0);
        chk("R11", "low off", low, 0);
        chk("R11", "fixed off", fixed, 0);
        cyc_end = 1; ilim = 0; step();
        chk("R11", "term off", term, 0);
        hot = 0; ls_on = 0; cyc_end = 0; step();
        chk("R11", "low after resume", low, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule